// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This block is a system watchdog. Software writes a control word that enables the timer, picks one of four power-of-two timeout lengths and picks the expiry action. The action is a normal interrupt request, a fast interrupt request, or a one-cycle system reset request. While the timer is enabled, a free-running counter advances on every clock. If the counter reaches the selected limit before software services it, the chosen action fires.

Servicing takes two writes to a dedicated service register, in a fixed order: first 0x123, then 0x321. Only the completed pair restarts the count, so a single stray write cannot keep a runaway program alive. A pending interrupt request stays raised until software completes a service or clears the enable. A reset request is a single pulse, and the count restarts from zero after it.

Top module: `wdt_keyed`

## Requirements
- R1: After reset, `wd_irq`, `wd_fiq` and `wd_rst_req` are low and the control register reads as zero.
- R2: The counter advances only while control bit 24 is set. While that bit is clear, the counter stays at zero and no output asserts, however long the timer sits idle.
- R3: Control bits 21:20 select the timeout: 00 gives 2^TMO_EXP0 clocks, 01 gives 2^TMO_EXP1, 10 gives 2^TMO_EXP2 and 11 gives 2^TMO_EXP3 (defaults 24, 26, 28, 29). The action output asserts exactly that many clock edges after the edge that loaded the enable.
- R4: Control bits 23:22 select the action: 00 sets `wd_irq`, 01 sets `wd_fiq`, 10 pulses `wd_rst_req`, and 11 drives no output.
- R5: Writing 0x123 and then 0x321 to offset 0x0C completes a service. A service clears the counter, so the next expiry comes a full timeout after the edge of the 0x321 write. The control register sits at offset 0x00.
- R6: Once `wd_irq` or `wd_fiq` is set, it stays high until a service completes. It is also cleared one clock after control bit 24 is written to zero.
- R7: After 0x123, a write of any other value except 0x321 to the service offset discards the partial sequence. Writing 0x123 again keeps the sequence armed. Writes to other offsets leave the sequence unchanged.
- R8: A reset request lasts exactly one clock. The counter then restarts, so an unserviced watchdog pulses once per timeout.
- R9: The action and timeout fields are used as currently held. If the timeout is shortened below the current count, expiry occurs on the next clock.
- R10: Reading offset 0x00 returns bits 24:20 as last written and zero in every other bit. Reading offset 0x0C returns zero.
- R11: A service that completes on the same edge as an expiry takes precedence, and no action fires on that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| wd_irq | output | 1 | Held interrupt request on expiry |
| wd_fiq | output | 1 | Held fast interrupt request on expiry |
| wd_rst_req | output | 1 | One-cycle system reset request on expiry |

## Verification
Directed patterns come first. Each timeout select is run from enable to expiry, which tells a correct limit apart from an off-by-one count or a wrong exponent. Several service patterns follow: a clean pair, a pair broken by a foreign value, a repeated first key, a pair with a write to another offset in between, and a second key landing on the expiry edge. Because the expiry edge moves or stays put, these patterns tell a true counter clear from an ignored or wrongly ordered key. Random rounds then mix key writes, junk values, control rewrites and idle gaps, and compare all three outputs every cycle against a cycle model in the bench.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic [1:0] {
    ACT_IRQ   = 2'b00,
    ACT_FIQ   = 2'b01,
    ACT_RESET = 2'b10,
    ACT_NONE  = 2'b11
  } wdt_act_e;

  typedef struct packed {
    logic     en;
    wdt_act_e act;
    logic [1:0] tsel;
  } wdt_cfg_t;

  localparam int unsigned CTRL_EN_BIT  = 24;
  localparam int unsigned CTRL_ACT_LSB = 22;
  localparam int unsigned CTRL_TMO_LSB = 20;
  localparam int unsigned BUS_DW       = 32;

  localparam logic [BUS_DW-1:0] KEY_FIRST  = 32'h0000_0123;
  localparam logic [BUS_DW-1:0] KEY_SECOND = 32'h0000_0321;

  function automatic int max4(input int a, input int b, input int c, input int d);
    int m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction

  function automatic logic [63:0] pow2m1(input int e);
    return (64'd1 << e) - 64'd1;
  endfunction

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
  parameter logic [ADDR_W-1:0] SVC_OFS  = 'h0C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_DW-1:0] bus_wdata,
  output logic [BUS_DW-1:0] bus_rdata,
  output wdt_cfg_t          cfg,
  output logic              svc_wr,
  output logic [BUS_DW-1:0] svc_data
);

  wdt_cfg_t cfg_q, cfg_d;
  logic     ctrl_wr;

  assign ctrl_wr  = bus_wr && (bus_addr == CTRL_OFS);
  assign svc_wr   = bus_wr && (bus_addr == SVC_OFS);
  assign svc_data = bus_wdata;
  assign cfg      = cfg_q;

  always_comb begin
    cfg_d      = cfg_q;
    cfg_d.en   = bus_wdata[CTRL_EN_BIT];
    cfg_d.act  = wdt_act_e'(bus_wdata[CTRL_ACT_LSB +: 2]);
    cfg_d.tsel = bus_wdata[CTRL_TMO_LSB +: 2];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (ctrl_wr) begin
      cfg_q <= cfg_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == CTRL_OFS) begin
      bus_rdata[CTRL_EN_BIT]           = cfg_q.en;
      bus_rdata[CTRL_ACT_LSB +: 2]     = cfg_q.act;
      bus_rdata[CTRL_TMO_LSB +: 2]     = cfg_q.tsel;
    end
  end

  AST_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(cfg_q)) else $error("config changed without write"); // R10

endmodule

// File: rtl/wdt_key_seq.sv
module wdt_key_seq
  import wdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              svc_wr,
  input  logic [BUS_DW-1:0] svc_data,
  output logic              svc_done
);

  logic armed_q, armed_d;

  always_comb begin
    armed_d  = armed_q;
    svc_done = 1'b0;
    if (svc_wr) begin
      if (svc_data == KEY_FIRST) begin
        armed_d = 1'b1;
      end else if (armed_q && (svc_data == KEY_SECOND)) begin
        armed_d  = 1'b0;
        svc_done = 1'b1;
      end else begin
        armed_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (svc_wr) begin
      armed_q <= armed_d;
    end
  end

  AST_DONE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    svc_done |=> !armed_q) else $error("sequence still armed after completion"); // R7

  AST_ARM_NEEDS_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(armed_q) |-> $past(svc_wr && (svc_data == KEY_FIRST)))
    else $error("armed without first key"); // R5

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter
  import wdt_pkg::*;
#(
  parameter int unsigned TMO_EXP0 = 24,
  parameter int unsigned TMO_EXP1 = 26,
  parameter int unsigned TMO_EXP2 = 28,
  parameter int unsigned TMO_EXP3 = 29,
  localparam int unsigned CNT_W   = max4(TMO_EXP0, TMO_EXP1, TMO_EXP2, TMO_EXP3)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [1:0] tsel,
  input  logic       clr,
  output logic       hit
);

  logic [CNT_W-1:0] lim_tab [4];
  logic [CNT_W-1:0] lim_sel;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_upd;

  for (genvar g = 0; g < 4; g++) begin : g_lim
    localparam int unsigned EXP_G = (g == 0) ? TMO_EXP0 :
                                    (g == 1) ? TMO_EXP1 :
                                    (g == 2) ? TMO_EXP2 : TMO_EXP3;
    assign lim_tab[g] = CNT_W'(pow2m1(int'(EXP_G)));
  end

  assign lim_sel = lim_tab[tsel];
  assign hit     = en && !clr && (cnt_q >= lim_sel);
  assign cnt_upd = en || (cnt_q != '0);

  always_comb begin
    if (!en || clr || hit) cnt_d = '0;
    else                   cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_upd) begin
      cnt_q <= cnt_d;
    end
  end

  AST_OFF_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (cnt_q == '0)) else $error("counter ran while disabled"); // R2

  AST_EXPIRY_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (cnt_q == '0)) else $error("counter not restarted after expiry"); // R8

  AST_CLR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (cnt_q == '0)) else $error("service did not clear counter"); // R5

endmodule

// File: rtl/wdt_action.sv
module wdt_action
  import wdt_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  input  wdt_act_e act,
  input  logic     hit,
  input  logic     svc_done,
  output logic     irq,
  output logic     fiq,
  output logic     rst_req
);

  logic irq_q, irq_d;
  logic fiq_q, fiq_d;
  logic rst_q, rst_d;
  logic flag_upd;

  assign flag_upd = !en || svc_done || hit;

  always_comb begin
    irq_d = irq_q;
    fiq_d = fiq_q;
    if (!en || svc_done) begin
      irq_d = 1'b0;
      fiq_d = 1'b0;
    end else if (hit) begin
      if (act == ACT_IRQ) irq_d = 1'b1;
      if (act == ACT_FIQ) fiq_d = 1'b1;
    end
    rst_d = hit && (act == ACT_RESET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else if (flag_upd) begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= rst_d;
  end

  assign irq     = irq_q;
  assign fiq     = fiq_q;
  assign rst_req = rst_q;

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rst_q |=> !rst_q) else $error("reset request longer than one cycle"); // R8

  AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && en && !svc_done) |=> irq_q) else $error("irq dropped without service"); // R6

  AST_FIQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (fiq_q && en && !svc_done) |=> fiq_q) else $error("fiq dropped without service"); // R6

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!irq_q && !fiq_q && !rst_q)) else $error("output while disabled"); // R2

endmodule

// File: rtl/wdt_keyed.sv
module wdt_keyed
  import wdt_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] CTRL_OFS = 'h00,
  parameter logic [ADDR_W-1:0] SVC_OFS  = 'h0C,
  parameter int unsigned       TMO_EXP0 = 24,
  parameter int unsigned       TMO_EXP1 = 26,
  parameter int unsigned       TMO_EXP2 = 28,
  parameter int unsigned       TMO_EXP3 = 29
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              wd_irq,
  output logic              wd_fiq,
  output logic              wd_rst_req
);

  wdt_cfg_t          cfg;
  logic              svc_wr;
  logic [BUS_DW-1:0] svc_data;
  logic              svc_done;
  logic              hit;

  wdt_regs #(
    .ADDR_W   (ADDR_W),
    .CTRL_OFS (CTRL_OFS),
    .SVC_OFS  (SVC_OFS)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .cfg       (cfg),
    .svc_wr    (svc_wr),
    .svc_data  (svc_data)
  );

  wdt_key_seq u_keys (
    .clk      (clk),
    .rst_n    (rst_n),
    .svc_wr   (svc_wr),
    .svc_data (svc_data),
    .svc_done (svc_done)
  );

  wdt_counter #(
    .TMO_EXP0 (TMO_EXP0),
    .TMO_EXP1 (TMO_EXP1),
    .TMO_EXP2 (TMO_EXP2),
    .TMO_EXP3 (TMO_EXP3)
  ) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .en    (cfg.en),
    .tsel  (cfg.tsel),
    .clr   (svc_done),
    .hit   (hit)
  );

  wdt_action u_act (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (cfg.en),
    .act      (cfg.act),
    .hit      (hit),
    .svc_done (svc_done),
    .irq      (wd_irq),
    .fiq      (wd_fiq),
    .rst_req  (wd_rst_req)
  );

  AST_SVC_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (svc_done && !wd_irq && !wd_fiq) |=> (!wd_irq && !wd_fiq && !wd_rst_req))
    else $error("action fired on a service edge"); // R11

endmodule

// File: tb/wdt_keyed_tb.sv
module wdt_keyed_tb;

  localparam int CLK_PERIOD = 10;
  localparam int E0 = 3, E1 = 5, E2 = 7, E3 = 8;
  localparam logic [7:0] A_CTRL = 8'h00, A_SVC = 8'h0C, A_OTHER = 8'h08;
  localparam logic [31:0] K1 = 32'h123, K2 = 32'h321;
  localparam logic [31:0] EN = 32'h0100_0000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        wd_irq, wd_fiq, wd_rst_req;

  int n_chk = 0, n_fail = 0;
  bit finished = 1'b0;

  // reference model state
  int m_cnt = 0;
  bit m_irq = 0, m_fiq = 0, m_rst = 0, m_armed = 0, m_en = 0;
  int m_act = 0, m_tsel = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_keyed #(
    .ADDR_W (8), .TMO_EXP0 (E0), .TMO_EXP1 (E1), .TMO_EXP2 (E2), .TMO_EXP3 (E3)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .bus_wr (bus_wr), .bus_addr (bus_addr),
    .bus_wdata (bus_wdata), .bus_rdata (bus_rdata),
    .wd_irq (wd_irq), .wd_fiq (wd_fiq), .wd_rst_req (wd_rst_req)
  );

  function automatic int lim_of(input int s);
    case (s)
      0: return 1 << E0;
      1: return 1 << E1;
      2: return 1 << E2;
      default: return 1 << E3;
    endcase
  endfunction

  function automatic logic [31:0] ctrl(input int act, input int tsel);
    return EN | (32'(act & 3) << 22) | (32'(tsel & 3) << 20);
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] want);
    n_chk++;
    if (got !== want) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, got, want, $time);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  // one clock edge, optionally with a write; model advanced, outputs compared
  task automatic step(input bit wr, input logic [7:0] a, input logic [31:0] d);
    bit done, hit, arm_n;
    bus_wr = wr; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
    done = 0; arm_n = m_armed;
    if (wr && a == A_SVC) begin
      if (d == K1) arm_n = 1;
      else if (m_armed && d == K2) begin arm_n = 0; done = 1; end
      else arm_n = 0;
    end
    hit = m_en && !done && (m_cnt >= lim_of(m_tsel) - 1);
    if (!m_en || done || hit) m_cnt = 0; else m_cnt++;
    if (!m_en || done) begin m_irq = 0; m_fiq = 0; end
    else if (hit) begin
      if (m_act == 0) m_irq = 1;
      if (m_act == 1) m_fiq = 1;
    end
    m_rst = hit && (m_act == 2);
    if (wr && a == A_CTRL) begin
      m_en = d[24]; m_act = int'(d[23:22]); m_tsel = int'(d[21:20]);
    end
    m_armed = arm_n;
    chk("R4 irq model", 32'(wd_irq), 32'(m_irq));
    chk("R4 fiq model", 32'(wd_fiq), 32'(m_fiq));
    chk("R8 reset model", 32'(wd_rst_req), 32'(m_rst));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, A_CTRL, 0);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    step(1, a, d);
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a; #1; d = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    logic [31:0] rv;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(A_CTRL, rv);
    chk("R1 ctrl readback", rv, 0);
    chk("R1 outputs", {wd_irq, wd_fiq, wd_rst_req}, 0);

    // R2 disabled: nothing happens
    idle(300);
    chk("R2 disabled quiet", {wd_irq, wd_fiq, wd_rst_req}, 0);

    // R10 readback masking, R4 action 11 gives no output
    wr(A_CTRL, 32'hFFFF_FFFF);
    rd(A_CTRL, rv);
    chk("R10 ctrl mask", rv, 32'h01F0_0000);
    rd(A_SVC, rv);
    chk("R10 svc reads zero", rv, 0);
    idle(lim_of(3) * 2 + 3);
    chk("R4 action none", {wd_irq, wd_fiq, wd_rst_req}, 0);
    wr(A_CTRL, 0);

    // R3 each timeout select, exact edge
    for (int s = 0; s < 4; s++) begin
      wr(A_CTRL, 0); idle(1);
      wr(A_CTRL, ctrl(0, s));
      idle(lim_of(s) - 1);
      chk("R3 before timeout", 32'(wd_irq), 0);
      idle(1);
      chk("R3 at timeout", 32'(wd_irq), 1);
    end

    // R6 sticky, R5 service clears and restarts
    idle(50);
    chk("R6 irq held", 32'(wd_irq), 1);
    wr(A_SVC, K1); wr(A_SVC, K2);
    chk("R5 service clears irq", 32'(wd_irq), 0);
    idle(lim_of(3) - 1);
    chk("R5 restart before", 32'(wd_irq), 0);
    idle(1);
    chk("R5 restart at", 32'(wd_irq), 1);
    wr(A_CTRL, 0);
    idle(1);
    chk("R6 disable clears", 32'(wd_irq), 0);

    // R4 fiq action
    wr(A_CTRL, ctrl(1, 0));
    idle(lim_of(0));
    chk("R4 fiq set", {wd_irq, wd_fiq}, 2'b01);
    wr(A_CTRL, 0); idle(1);

    // R7 broken sequence does not clear
    wr(A_CTRL, ctrl(0, 0));                 // E
    wr(A_SVC, K1); wr(A_SVC, 32'h555); wr(A_SVC, K2);  // E+3
    idle(4);
    chk("R7 broken seq before", 32'(wd_irq), 0);
    idle(1);
    chk("R7 broken seq no clear", 32'(wd_irq), 1);
    wr(A_CTRL, 0); idle(1);

    // R7 repeated first key and foreign-offset write keep arming
    wr(A_CTRL, ctrl(0, 0));                 // E
    idle(3);
    wr(A_SVC, K1); wr(A_OTHER, K2); wr(A_SVC, K1); wr(A_SVC, K2);  // clear at E+7
    idle(1);
    chk("R7 armed kept", 32'(wd_irq), 0);   // E+8
    idle(6);
    chk("R7 restart before", 32'(wd_irq), 0);
    idle(1);
    chk("R7 restart at", 32'(wd_irq), 1);   // E+15
    wr(A_CTRL, 0); idle(1);

    // R8 periodic one-cycle reset pulses
    wr(A_CTRL, ctrl(2, 0));
    for (int k = 1; k <= 17; k++) begin
      idle(1);
      chk("R8 reset pulse", 32'(wd_rst_req), 32'((k == 8) || (k == 16)));
    end
    wr(A_CTRL, 0); idle(1);

    // R9 shrinking timeout below current count
    wr(A_CTRL, ctrl(0, 3));
    idle(100);
    wr(A_CTRL, ctrl(0, 0));
    chk("R9 not yet", 32'(wd_irq), 0);
    idle(1);
    chk("R9 immediate expiry", 32'(wd_irq), 1);
    wr(A_CTRL, 0); idle(1);

    // R11 service on the expiry edge wins
    wr(A_CTRL, ctrl(0, 0));                 // E
    wr(A_SVC, K1);                          // E+1
    idle(6);                                // E+7
    wr(A_SVC, K2);                          // E+8
    chk("R11 service beats expiry", 32'(wd_irq), 0);
    idle(7);
    chk("R11 later before", 32'(wd_irq), 0);
    idle(1);
    chk("R11 later expiry", 32'(wd_irq), 1);
    wr(A_CTRL, 0); idle(1);

    // random rounds
    for (int r = 0; r < 40; r++) begin
      wr(A_CTRL, ctrl(int'($urandom % 4), int'($urandom % 3)));
      for (int i = 0; i < 200; i++) begin
        int p;
        p = int'($urandom % 100);
        if (p < 12)      wr(A_SVC, K1);
        else if (p < 20) wr(A_SVC, K2);
        else if (p < 24) wr(A_SVC, $urandom);
        else if (p < 27) wr(A_CTRL, ($urandom & ~32'h0030_0000) | ((p & 1) ? EN : 0));
        else if (p < 32) wr(A_OTHER, K2);
        else             idle(1);
      end
    end
    rd(A_CTRL, rv);
    chk("R10 random readback", rv,
        (32'(m_en) << 24) | (32'(m_act) << 22) | (32'(m_tsel) << 20));

    summary();
  end

endmodule